// File: doc/BRIEF.md
# Flag-Setting Logical Left Shifter

This unit performs a logical left shift on an operand held in the low part of a 32-bit register value. The operand is a byte (bits 7:0), a word (bits 15:0) or a longword (all 32 bits). Only that lane is rewritten. The bits above it are returned exactly as they came in. Zeros enter from the right. Bits pushed past the operand's top bit are lost, and the last of them is reported as the carry flag.

The shift distance has two possible sources. It can come from a small immediate code, and each operand size accepts only part of the immediate codes. It can also come from the low five bits of a count byte taken from another register. The count register itself is never written.

The unit registers its result. The merged register value and the H, N, Z, V, C flags appear one clock after an input strobe. An immediate code that the chosen size does not accept, or an unused size code, raises an error output, and the register value then passes through untouched.

Top module: `shl_unit`

## Requirements
- R1: While reset (rstN low) is applied, and until the first accepted input, outValid, illegal, regOut and all five flags are 0.
- R2: Only the selected lane is rewritten. sizeSel 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 = longword (bits 31:0). Register bits above the lane equal the input bits.
- R3: The lane result is the operand shifted left with zeros filled in from the right. Bits moved past the operand's top bit are discarded.
- R4: flagC equals original operand bit (width − count) when 1 ≤ count ≤ width, and is 0 when the count is 0 or exceeds the width.
- R5: flagN equals the top bit of the sized result, and flagZ is 1 exactly when the sized result is zero.
- R6: flagH and flagV are always 0.
- R7: With useReg = 0, the immediate code maps 0→1, 1→2, 2→4, 3→8, 4→16. Byte accepts codes 0–1, word accepts 0–3, longword accepts 0–4.
- R8: A code the size does not accept, a code of 5–7, or sizeSel 3 sets illegal = 1 and returns regOut equal to regIn, with C, N and Z all 0.
- R9: With useReg = 1, the count is cntByte[4:0], and bits 7:5 are ignored. For byte and word, a count at or above the width gives a zero result. A count of 0 leaves the operand unchanged with C = 0.
- R10: Results appear on the clock edge after inValid is high, with outValid high for that one cycle. While inValid is low, regOut, the flags and illegal hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| regIn | input | 32 | Register contents holding the operand |
| sizeSel | input | 2 | Operand size: 0 byte, 1 word, 2 longword, 3 unused |
| useReg | input | 1 | 1 = count from cntByte, 0 = immediate code |
| immCode | input | 3 | Immediate shift code |
| cntByte | input | 8 | Count byte from the second register |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| regOut | output | 32 | Merged register result |
| flagH | output | 1 | Half-carry flag, always clear |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag, always clear |
| flagC | output | 1 | Last bit shifted out |
| illegal | output | 1 | Rejected size or immediate code |

## Verification
The bench builds the unit with the package defaults: a 32-bit datapath, four byte lanes and a 5-bit count. With that count width, register counts from 0 to 31 are tried on every size. This covers counts exactly equal to the byte and word widths as well as counts above them, so the carry-from-bit-0 case and the all-zero result are both exercised. All eight immediate codes are also swept against all four size codes, so every accepted code and every rejected code is seen.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int CNT_W     = $clog2(DATA_W);
  localparam int IMM_W     = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  typedef struct packed {
    logic                  err;
    size_e                 size;
    logic [NUM_LANES-1:0]  laneWr;
    logic [CNT_W-1:0]      amt;
  } shl_ctrl_t;
endpackage

// File: rtl/shl_ctrl.sv
module shl_ctrl
  import shl_pkg::*;
(
  input  logic [1:0]       sizeSel,
  input  logic             useReg,
  input  logic [IMM_W-1:0] immCode,
  input  logic [7:0]       cntByte,
  output shl_ctrl_t        ctrl
);
  size_e            sizeCode;
  logic [IMM_W-1:0] maxCode;
  logic [CNT_W-1:0] immAmt;
  logic             badImm;
  logic             err;
  int               lanesUsed;
  logic [NUM_LANES-1:0] laneWr;
  logic             unusedCntHi;

  assign sizeCode    = size_e'(sizeSel);
  assign unusedCntHi = ^cntByte[7:CNT_W];

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: begin maxCode = IMM_W'(1); lanesUsed = 1; end
      SZ_WORD: begin maxCode = IMM_W'(3); lanesUsed = 2; end
      SZ_LONG: begin maxCode = IMM_W'(4); lanesUsed = NUM_LANES; end
      default: begin maxCode = '0;        lanesUsed = 0; end
    endcase
  end

  assign immAmt = CNT_W'(1) << immCode;
  assign badImm = !useReg && (immCode > maxCode);
  assign err    = (sizeCode == SZ_NONE) || badImm;

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    assign laneWr[gi] = !err && (gi < lanesUsed);
  end

  always_comb begin
    ctrl.err    = err;
    ctrl.size   = sizeCode;
    ctrl.laneWr = laneWr;
    ctrl.amt    = useReg ? cntByte[CNT_W-1:0] : immAmt;
  end
endmodule

// File: rtl/shl_datapath.sv
module shl_datapath
  import shl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] regIn,
  input  shl_ctrl_t         ctrl,
  output logic              outValid,
  output logic [DATA_W-1:0] regOut,
  output logic              flagH,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic              illegal
);
  logic [DATA_W-1:0] opnd;
  logic [DATA_W:0]   ext;
  logic [DATA_W-1:0] res;
  logic [DATA_W-1:0] merged;
  logic              carry;
  logic              msb;

  for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
    assign opnd[gl*LANE_W +: LANE_W]   = ctrl.laneWr[gl] ? regIn[gl*LANE_W +: LANE_W] : '0;
    assign res[gl*LANE_W +: LANE_W]    = ctrl.laneWr[gl] ? ext[gl*LANE_W +: LANE_W] : '0;
    assign merged[gl*LANE_W +: LANE_W] = ctrl.laneWr[gl] ? res[gl*LANE_W +: LANE_W]
                                                         : regIn[gl*LANE_W +: LANE_W];
  end

  assign ext = {1'b0, opnd} << ctrl.amt;

  always_comb begin
    unique case (ctrl.size)
      SZ_BYTE: begin carry = ext[LANE_W];     msb = res[LANE_W-1];     end
      SZ_WORD: begin carry = ext[2*LANE_W];   msb = res[2*LANE_W-1];   end
      SZ_LONG: begin carry = ext[DATA_W];     msb = res[DATA_W-1];     end
      default: begin carry = 1'b0;            msb = 1'b0;              end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      regOut   <= '0;
      flagH    <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        regOut  <= merged;
        flagH   <= 1'b0;
        flagV   <= 1'b0;
        flagN   <= !ctrl.err && msb;
        flagZ   <= !ctrl.err && (res == '0);
        flagC   <= !ctrl.err && carry;
        illegal <= ctrl.err;
      end
    end
  end

  // R6
  hv_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagH && !flagV);

  // R8
  err_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegal) |-> (regOut == $past(regIn) && !flagC && !flagN && !flagZ));

  // R2
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal && $past(ctrl.size) == SZ_BYTE)
      |-> (regOut[DATA_W-1:LANE_W] == $past(regIn[DATA_W-1:LANE_W])));

  // R5
  zn_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagZ |-> !flagN);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(regOut) && $stable(flagC) && $stable(illegal)));

  // R9
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !illegal && $past(ctrl.amt) == '0) |-> (regOut == $past(regIn) && !flagC));
endmodule

// File: rtl/shl_unit.sv
module shl_unit
  import shl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] regIn,
  input  logic [1:0]        sizeSel,
  input  logic              useReg,
  input  logic [IMM_W-1:0]  immCode,
  input  logic [7:0]        cntByte,
  output logic              outValid,
  output logic [DATA_W-1:0] regOut,
  output logic              flagH,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic              illegal
);
  shl_ctrl_t ctrl;

  shl_ctrl u_ctrl (
    .sizeSel (sizeSel),
    .useReg  (useReg),
    .immCode (immCode),
    .cntByte (cntByte),
    .ctrl    (ctrl)
  );

  shl_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .regIn    (regIn),
    .ctrl     (ctrl),
    .outValid (outValid),
    .regOut   (regOut),
    .flagH    (flagH),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC),
    .illegal  (illegal)
  );
endmodule

// File: tb/shl_unit_tb.sv
module shl_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] regIn = '0;
  logic [1:0]  sizeSel = '0;
  logic        useReg = 1'b0;
  logic [2:0]  immCode = '0;
  logic [7:0]  cntByte = '0;
  logic        outValid;
  logic [31:0] regOut;
  logic        flagH, flagN, flagZ, flagV, flagC, illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shl_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .regIn(regIn),
    .sizeSel(sizeSel), .useReg(useReg), .immCode(immCode), .cntByte(cntByte),
    .outValid(outValid), .regOut(regOut), .flagH(flagH), .flagN(flagN),
    .flagZ(flagZ), .flagV(flagV), .flagC(flagC), .illegal(illegal)
  );

  // {regIn, size, useReg, imm, cnt, expOut, C, N, Z, err}
  localparam int NV = 21;
  localparam logic [81:0] VECS [NV] = '{
    {32'hA5A5A5A5, 2'd0, 1'b0, 3'd0, 8'h00, 32'hA5A5A54A, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd0, 1'b0, 3'd1, 8'h00, 32'hA5A5A594, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd0, 1'b1, 3'd0, 8'hA5, 32'hA5A5A5A0, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd1, 1'b0, 3'd0, 8'h00, 32'hA5A54B4A, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd1, 1'b0, 3'd1, 8'h00, 32'hA5A59694, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd1, 1'b0, 3'd2, 8'h00, 32'hA5A55A50, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd1, 1'b0, 3'd3, 8'h00, 32'hA5A5A500, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd1, 1'b1, 3'd0, 8'hA5, 32'hA5A5B4A0, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b0, 3'd0, 8'h00, 32'h4B4B4B4A, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b0, 3'd1, 8'h00, 32'h96969694, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b0, 3'd2, 8'h00, 32'h5A5A5A50, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b0, 3'd3, 8'h00, 32'hA5A5A500, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b0, 3'd4, 8'h00, 32'hA5A50000, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd2, 1'b1, 3'd0, 8'hA5, 32'hB4B4B4A0, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'hA5A5A5A5, 2'd0, 1'b0, 3'd2, 8'h00, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'hA5A5A5A5, 2'd3, 1'b0, 3'd0, 8'h00, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'h0F0F8001, 2'd1, 1'b0, 3'd4, 8'h00, 32'h0F0F8001, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'h12345601, 2'd0, 1'b1, 3'd0, 8'h08, 32'h12345600, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h123456FF, 2'd0, 1'b1, 3'd0, 8'h09, 32'h12345600, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h80000001, 2'd2, 1'b1, 3'd0, 8'h20, 32'h80000001, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h55555555, 2'd2, 1'b0, 3'd5, 8'h00, 32'h55555555, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent reference: one bit per step
  task automatic refModel(input logic [31:0] rin, input logic [1:0] sz, input logic ur,
                          input logic [2:0] ic, input logic [7:0] cb,
                          output logic [31:0] rout, output logic [3:0] flg);
    int w;
    int maxc;
    int amt;
    logic [31:0] op;
    logic c;
    logic bad;
    case (sz)
      2'd0: begin w = 8;  maxc = 1; end
      2'd1: begin w = 16; maxc = 3; end
      2'd2: begin w = 32; maxc = 4; end
      default: begin w = 0; maxc = -1; end
    endcase
    bad = (w == 0) || (!ur && int'(ic) > maxc);
    if (bad) begin
      rout = rin;
      flg = 4'b0001;
      return;
    end
    amt = ur ? int'(cb % 32) : (1 << ic);
    op = (w == 32) ? rin : (rin & ((32'd1 << w) - 1));
    c = 1'b0;
    for (int k = 0; k < amt; k++) begin
      c = op[w-1];
      op = op << 1;
      if (w < 32) op = op & ((32'd1 << w) - 1);
    end
    rout = (w == 32) ? op : ((rin & ~((32'd1 << w) - 1)) | op);
    flg = {c, op[w-1], (op == 0), 1'b0};
  endtask

  task automatic apply(input logic [31:0] rin, input logic [1:0] sz, input logic ur,
                       input logic [2:0] ic, input logic [7:0] cb);
    @(negedge clk);
    regIn = rin; sizeSel = sz; useReg = ur; immCode = ic; cntByte = cb;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runOne(input string req, input logic [31:0] rin, input logic [1:0] sz,
                        input logic ur, input logic [2:0] ic, input logic [7:0] cb);
    logic [31:0] eo;
    logic [3:0] ef;
    refModel(rin, sz, ur, ic, cb, eo, ef);
    apply(rin, sz, ur, ic, cb);
    chk(req, "regOut", regOut, eo);
    chk(req, "C,N,Z,err", {28'd0, flagC, flagN, flagZ, illegal}, {28'd0, ef});
    chk("R6", "H,V", {30'd0, flagH, flagV}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset outputs", {regOut[31:0]}, 32'd0);
    chk("R1", "reset flags", {25'd0, outValid, flagH, flagN, flagZ, flagV, flagC, illegal}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "after release", {25'd0, outValid, flagH, flagN, flagZ, flagV, flagC, illegal}, 32'd0);

    // Table: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VECS[i];
      apply(v[81:50], v[49:48], v[47], v[46:44], v[43:36]);
      chk("R2/R3/R7 vec", "regOut", regOut, v[35:4]);
      chk("R4/R5/R8 vec", "C,N,Z,err", {28'd0, flagC, flagN, flagZ, illegal}, {28'd0, v[3:0]});
    end

    // R7 R8: every immediate code on every size code
    for (int s = 0; s < 4; s++)
      for (int ic = 0; ic < 8; ic++)
        runOne("R7", 32'hC3A58E71, 2'(s), 1'b0, 3'(ic), 8'h00);

    // R9 R4: every register count, upper count bits set
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 32; c++)
        runOne("R9", 32'h9E3779B9 ^ (32'(c) << 3), 2'(s), 1'b1, 3'd7, 8'(c) | 8'hE0);

    // R10: strobe timing and hold
    @(negedge clk);
    regIn = 32'h000000C1; sizeSel = 2'd0; useReg = 1'b0; immCode = 3'd0; inValid = 1'b1;
    @(posedge clk); #1;
    chk("R10", "outValid at edge", {31'd0, outValid}, 32'd1);
    @(negedge clk);
    inValid = 1'b0;
    regIn = 32'hFFFFFFFF; sizeSel = 2'd3;
    chk("R10", "result", regOut, 32'h00000082);
    @(negedge clk);
    chk("R10", "outValid drop", {31'd0, outValid}, 32'd0);
    chk("R10", "hold regOut", regOut, 32'h00000082);
    chk("R10", "hold flags", {28'd0, flagC, flagN, flagZ, illegal}, 32'b1100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule